// File: doc/BRIEF.md
# Sync-Referenced Up/Down Frequency Error Counter

This block measures how far a free-running oscillator drifts from its target rate by counting its own clock cycles between two reference pulses. Each reference pulse loads a programmable start value and the counter walks down towards zero. Hitting zero marks the moment the next reference pulse should arrive, and the block emits a one-cycle expected-sync pulse. From there the counter turns around and counts up. If no pulse comes before the count reaches 128 times a programmable limit, the counter freezes and raises a missed-sync flag.

Every reference pulse after the first one captures the running count and the current counting direction together, and emits a capture strobe. A downstream stage uses these to decide whether the oscillator is slow (pulse came while counting down) or fast (pulse came while counting up), and by how much. The reload value and the limit are held in an internal configuration store. A write strobe updates the store only while counting is disabled.

Top module: `sync_err_counter`

## Requirements
- R1: After reset, the capture value is 0, the captured direction is 0, and the capture strobe, the expected-sync pulse and the missed-sync flag are all low.
- R2: A sync pulse sampled while enabled loads the stored reload value R and counts down by one per clock. A second sync g clocks after the first, with g-1 < R, captures R-(g-1) with direction 1 (1 = counting down).
- R3: The expected-sync output is high for exactly one cycle, in the cycle after the R-th clock edge following the loading sync. The counter is 0 at that point and counts up from then on.
- R4: A sync arriving g clocks after the loading sync, with g-1 >= R, captures the up-count g-1-R with direction 0 (0 = counting up), as long as that value does not exceed 128×limit.
- R5: When the up-count reaches 128×limit with no sync, the counter stops there and the missed-sync flag is set. A later sync captures that frozen value with direction 0 and clears the flag in the same edge.
- R6: The capture strobe is a one-cycle pulse in the cycle after each enabled sync, except the first sync after enable. That first sync only starts counting and leaves the capture outputs unchanged.
- R7: While enable is low, sync pulses produce no capture strobe and no expected-sync pulse, the missed-sync flag is cleared, and the next enable starts again with an uncaptured first sync.
- R8: The configuration write strobe updates the stored reload value and limit only while enable is low. A write while enabled leaves the stored values unchanged.
- R9: Without any configuration write, the stored reload value is 47999 and the stored limit is 34. The expected-sync pulse therefore follows the 47999th edge, and the missed flag follows a further 4352 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from the oscillator being measured |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Counting enable; also locks the configuration when high |
| sync_pulse | input | 1 | One-cycle reference pulse, synchronous to clk |
| cfg_write | input | 1 | Configuration write strobe, honoured only while disabled |
| reload_in | input | 16 | Reload value presented for a configuration write |
| limit_in | input | 8 | Error limit presented for a configuration write |
| cap_value | output | 16 | Count latched at the last capturing sync |
| cap_down | output | 1 | Direction latched at the last capturing sync (1 = down) |
| cap_strobe | output | 1 | One-cycle pulse when a capture has been taken |
| expect_pulse | output | 1 | One-cycle pulse when the down-count reaches zero |
| miss_flag | output | 1 | High while the up-count is frozen at 128×limit |

## Verification
The assertions assume that sync_pulse is already synchronous to clk and lasts one cycle. They also assume that the configuration is written only while counting is off, so the reload value and limit stay fixed for a whole measurement. The bench keeps to this: it raises every sync for a single cycle, and it changes the configuration with enable low. The one exception is the deliberate protected-write case, where the stored values must not move. Each table entry is also started from a disabled state, so the first sync of every measurement is the arming sync the assertions expect.

// File: rtl/sync_err_pkg.sv
// Shared widths, reset values and the direction type for the sync error counter.
package sync_err_pkg;
    localparam int CNT_W      = 16;
    localparam int LIM_W      = 8;
    localparam int LIM_SHIFT  = 7;
    localparam logic [CNT_W-1:0] RELOAD_RST = 16'd47999;
    localparam logic [LIM_W-1:0] LIMIT_RST  = 8'd34;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;
endpackage

// File: rtl/sync_err_cfg.sv
// Configuration store for the reload value and the error limit.
// Assumes: wr_i is a level sampled each clock; writes while en_i is high are dropped.
module sync_err_cfg #(
    parameter int CNT_W = 16,
    parameter int LIM_W = 8,
    parameter logic [CNT_W-1:0] RELOAD_RST = '0,
    parameter logic [LIM_W-1:0] LIMIT_RST  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic [CNT_W-1:0] reload_q,
    output logic [LIM_W-1:0] limit_q
);
    // Hold configuration; accept a write only while counting is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= RELOAD_RST;
            limit_q  <= LIMIT_RST;
        end else if (wr_i && !en_i) begin
            reload_q <= reload_i;
            limit_q  <= limit_i;
        end
    end

    // R8
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> ($stable(reload_q) && $stable(limit_q)));
endmodule

// File: rtl/sync_err_core.sv
// Reload down/up counter. A sync loads the reload value and counts down. Zero
// flags the expected sync and turns the count upward. The up-count freezes at
// limit<<SHIFT and raises the missed flag.
// Assumes: sync_i is one clock wide and synchronous; configuration is static while en_i.
module sync_err_core
    import sync_err_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int LIM_W     = 8,
    parameter int LIM_SHIFT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic [CNT_W-1:0] count_o,
    output cnt_dir_e         dir_o,
    output logic             armed_o,
    output logic             expect_o,
    output logic             miss_o
);
    localparam int LIM_EXT_W = LIM_W + LIM_SHIFT;

    logic [LIM_EXT_W-1:0] lim_shifted;
    logic [CNT_W-1:0]     out_range;
    logic [CNT_W-1:0]     count_inc;

    // Out-of-range bound formed by shifting the limit; fits the counter width.
    assign lim_shifted = {limit_i, {LIM_SHIFT{1'b0}}};
    assign out_range   = CNT_W'(lim_shifted);
    assign count_inc   = count_o + CNT_W'(1);

    // Count sequencing: reload on sync, down to zero, up to the bound, then freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o  <= '0;
            dir_o    <= DIR_DOWN;
            armed_o  <= 1'b0;
            expect_o <= 1'b0;
            miss_o   <= 1'b0;
        end else begin
            expect_o <= 1'b0;
            if (!en_i) begin
                armed_o <= 1'b0;
                miss_o  <= 1'b0;
            end else if (sync_i) begin
                count_o <= reload_i;
                dir_o   <= DIR_DOWN;
                armed_o <= 1'b1;
                miss_o  <= 1'b0;
            end else if (armed_o && !miss_o) begin
                if (dir_o == DIR_DOWN) begin
                    if (count_o <= CNT_W'(1)) begin
                        count_o  <= '0;
                        dir_o    <= DIR_UP;
                        expect_o <= 1'b1;
                    end else begin
                        count_o <= count_o - CNT_W'(1);
                    end
                end else if (count_o >= out_range) begin
                    miss_o <= 1'b1;
                end else begin
                    count_o <= count_inc;
                    if (count_inc == out_range) begin
                        miss_o <= 1'b1;
                    end
                end
            end
        end
    end

    // R2
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sync_i) |=> (count_o == $past(reload_i) && dir_o == DIR_DOWN));
    // R3
    expect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expect_o |=> !expect_o);
    // R3
    expect_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expect_o |-> (count_o == '0 && dir_o == DIR_UP));
    // R5
    miss_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_o && en_i && !sync_i) |=> ($stable(count_o) && miss_o));
    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!miss_o && !expect_o && !armed_o));
endmodule

// File: rtl/sync_err_capture.sv
// Atomic capture of count and direction at every sync after the arming one.
// Assumes: count_i and dir_i are the values registered before this edge.
module sync_err_capture
    import sync_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sync_i,
    input  logic             armed_i,
    input  logic [CNT_W-1:0] count_i,
    input  cnt_dir_e         dir_i,
    output logic [CNT_W-1:0] cap_value_o,
    output logic             cap_down_o,
    output logic             strobe_o
);
    logic take;

    assign take = en_i && sync_i && armed_i;

    // Latch value and direction together and pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_value_o <= '0;
            cap_down_o  <= 1'b0;
            strobe_o    <= 1'b0;
        end else begin
            strobe_o <= take;
            if (take) begin
                cap_value_o <= count_i;
                cap_down_o  <= (dir_i == DIR_DOWN);
            end
        end
    end

    // R6
    strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> $past(sync_i && en_i));
    // R6
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |-> (cap_value_o == $past(cap_value_o) || $past(strobe_o) == 1'b0));
endmodule

// File: rtl/sync_err_counter.sv
// Top of the sync-referenced frequency error counter: configuration store,
// reload down/up counter and capture stage.
// Assumes: sync_pulse is a single synchronous cycle per reference event.
module sync_err_counter
    import sync_err_pkg::*;
#(
    parameter int CNT_W     = sync_err_pkg::CNT_W,
    parameter int LIM_W     = sync_err_pkg::LIM_W,
    parameter int LIM_SHIFT = sync_err_pkg::LIM_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sync_pulse,
    input  logic             cfg_write,
    input  logic [CNT_W-1:0] reload_in,
    input  logic [LIM_W-1:0] limit_in,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_down,
    output logic             cap_strobe,
    output logic             expect_pulse,
    output logic             miss_flag
);
    logic [CNT_W-1:0] reload_q;
    logic [LIM_W-1:0] limit_q;
    logic [CNT_W-1:0] count;
    cnt_dir_e         dir;
    logic             armed;

    sync_err_cfg #(
        .CNT_W      (CNT_W),
        .LIM_W      (LIM_W),
        .RELOAD_RST (CNT_W'(RELOAD_RST)),
        .LIMIT_RST  (LIM_W'(LIMIT_RST))
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (enable),
        .wr_i     (cfg_write),
        .reload_i (reload_in),
        .limit_i  (limit_in),
        .reload_q (reload_q),
        .limit_q  (limit_q)
    );

    sync_err_core #(
        .CNT_W     (CNT_W),
        .LIM_W     (LIM_W),
        .LIM_SHIFT (LIM_SHIFT)
    ) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (enable),
        .sync_i   (sync_pulse),
        .reload_i (reload_q),
        .limit_i  (limit_q),
        .count_o  (count),
        .dir_o    (dir),
        .armed_o  (armed),
        .expect_o (expect_pulse),
        .miss_o   (miss_flag)
    );

    sync_err_capture #(
        .CNT_W (CNT_W)
    ) cap_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (enable),
        .sync_i      (sync_pulse),
        .armed_i     (armed),
        .count_i     (count),
        .dir_i       (dir),
        .cap_value_o (cap_value),
        .cap_down_o  (cap_down),
        .strobe_o    (cap_strobe)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!cap_strobe && !expect_pulse && !miss_flag));
endmodule

// File: tb/sync_err_counter_tb.sv
`timescale 1ns/1ps
module sync_err_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        sync_pulse = 1'b0;
    logic        cfg_write = 1'b0;
    logic [15:0] reload_in = '0;
    logic [7:0]  limit_in = '0;
    logic [15:0] cap_value;
    logic        cap_down;
    logic        cap_strobe;
    logic        expect_pulse;
    logic        miss_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    sync_err_counter dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .sync_pulse   (sync_pulse),
        .cfg_write    (cfg_write),
        .reload_in    (reload_in),
        .limit_in     (limit_in),
        .cap_value    (cap_value),
        .cap_down     (cap_down),
        .cap_strobe   (cap_strobe),
        .expect_pulse (expect_pulse),
        .miss_flag    (miss_flag)
    );

    // reload, limit, gap, expected value, expected direction, expected miss before sync
    typedef struct packed {
        logic [15:0] rl;
        logic [7:0]  lim;
        logic [15:0] gap;
        logic [15:0] val;
        logic        down;
        logic        miss;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'd20,  8'd1, 16'd10,  16'd11,  1'b1, 1'b0},
        '{16'd20,  8'd1, 16'd1,   16'd20,  1'b1, 1'b0},
        '{16'd20,  8'd1, 16'd20,  16'd1,   1'b1, 1'b0},
        '{16'd20,  8'd1, 16'd21,  16'd0,   1'b0, 1'b0},
        '{16'd20,  8'd1, 16'd31,  16'd10,  1'b0, 1'b0},
        '{16'd20,  8'd1, 16'd200, 16'd128, 1'b0, 1'b1},
        '{16'd100, 8'd2, 16'd50,  16'd51,  1'b1, 1'b0},
        '{16'd100, 8'd2, 16'd300, 16'd199, 1'b0, 1'b0},
        '{16'd100, 8'd2, 16'd400, 16'd256, 1'b0, 1'b1}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(); @(posedge clk); #5; endtask

    task automatic configure(input logic [15:0] rl, input logic [7:0] lim);
        enable = 1'b0; tick();
        reload_in = rl; limit_in = lim; cfg_write = 1'b1; tick();
        cfg_write = 1'b0;
    endtask

    // Arms with a first sync, then sends the second sync gap edges later.
    task automatic run_gap(input int gap, input string req, input logic exp_miss,
                           input int exp_val, input logic exp_down);
        enable = 1'b1; tick();
        sync_pulse = 1'b1; tick();
        sync_pulse = 1'b0;
        check("R6", "no strobe on arming sync", int'(cap_strobe), 0);
        for (int k = 1; k < gap; k++) tick();
        check("R5", "miss before sync", int'(miss_flag), int'(exp_miss));
        sync_pulse = 1'b1; tick();
        sync_pulse = 1'b0;
        check("R6", "strobe after sync", int'(cap_strobe), 1);
        check(req, "captured value", int'(cap_value), exp_val);
        check(req, "captured direction", int'(cap_down), int'(exp_down));
        check("R5", "miss cleared by sync", int'(miss_flag), 0);
        tick();
        check("R6", "strobe one cycle", int'(cap_strobe), 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", "cap_value", int'(cap_value), 0);
        check("R1", "cap_down", int'(cap_down), 0);
        check("R1", "strobe", int'(cap_strobe), 0);
        check("R1", "expect", int'(expect_pulse), 0);
        check("R1", "miss", int'(miss_flag), 0);

        // R9 default reload 47999 and limit 34 (4352 out-of-range count)
        enable = 1'b1; tick();
        sync_pulse = 1'b1; tick(); sync_pulse = 1'b0;
        for (int k = 1; k < 47999; k++) tick();
        check("R9", "no expect before zero", int'(expect_pulse), 0);
        tick();
        check("R9", "expect at default reload", int'(expect_pulse), 1);
        for (int k = 1; k < 4352; k++) tick();
        check("R9", "no miss before bound", int'(miss_flag), 0);
        tick();
        check("R9", "miss at default bound", int'(miss_flag), 1);

        // R2 R4 R5 R6 table walk
        for (int i = 0; i < NV; i++) begin
            configure(VECS[i].rl, VECS[i].lim);
            run_gap(int'(VECS[i].gap), VECS[i].down ? "R2" : "R4",
                    VECS[i].miss, int'(VECS[i].val), VECS[i].down);
        end

        // R3 expected-sync timing with reload 5
        configure(16'd5, 8'd1);
        enable = 1'b1; tick();
        sync_pulse = 1'b1; tick(); sync_pulse = 1'b0;
        for (int k = 1; k < 5; k++) tick();
        check("R3", "expect low before zero", int'(expect_pulse), 0);
        tick();
        check("R3", "expect at zero", int'(expect_pulse), 1);
        tick();
        check("R3", "expect one cycle", int'(expect_pulse), 0);

        // R7 disabled: sync ignored, miss cleared, re-arm needed
        configure(16'd5, 8'd1);
        sync_pulse = 1'b1; tick(); sync_pulse = 1'b0;
        check("R7", "no strobe while disabled", int'(cap_strobe), 0);
        for (int k = 0; k < 8; k++) tick();
        check("R7", "no expect while disabled", int'(expect_pulse), 0);
        check("R7", "no miss while disabled", int'(miss_flag), 0);
        enable = 1'b1; tick();
        sync_pulse = 1'b1; tick(); sync_pulse = 1'b0;
        check("R7", "first sync after enable uncaptured", int'(cap_strobe), 0);

        // R8 write while enabled is dropped: reload stays 20
        configure(16'd20, 8'd1);
        enable = 1'b1; tick();
        reload_in = 16'd5; cfg_write = 1'b1; tick(); cfg_write = 1'b0;
        run_gap(10, "R8", 1'b0, 11, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule